// File: doc/BRIEF.md
# Remapping Global Command Sequencer

This block is the command front end of an address-translation and interrupt-remapping engine. Software writes a 32-bit command word. Each bit that asks for work becomes one hardware operation, and the block runs these operations one at a time. Four operations are covered:

- flushing the internal write buffers;
- switching fault reporting between the fault recording registers and a log in memory;
- turning queued invalidation on or off;
- turning interrupt remapping on or off.

The command bits are triggers and are never stored for read-back. The outcome of each command appears in a separate status word, at the same bit position as its command. Every completed operation produces a one-cycle done pulse.

Two operations use a handshake. A flush holds a request until the buffer logic acknowledges it. An interrupt-remapping change first asks for a drain of the interrupts already queued, and applies the new setting only after the drain completes. The change therefore lands at a transaction boundary.

Enabling the memory fault log is honoured only while a fault-log pointer is valid. The fault-log and queued-invalidation changes complete without any handshake.

Top module: `remap_gcmd_top`

## Requirements
- R1: After synchronous reset the status word reads 0, and flush request, drain request, done, fault-to-log, queued-invalidation enable and remapping enable are all 0.
- R2: A read with rd_sel_i=0 (command word) returns 0. A read with rd_sel_i=1 returns the status word: fault-log status at bit 28, flush status at bit 27, queued-invalidation status at bit 26, remapping status at bit 25, and 0 in all other bits.
- R3: Writing 1 to bit 27 raises the flush request and status bit 27. Both stay high until a cycle with the flush acknowledge high. On that edge both clear and done pulses.
- R4: Writing 0 to bit 27 starts no flush: the flush request and status bit 27 stay 0.
- R5: A write of 1 to bit 28 sets the fault-log status only if the pointer-valid input is high when the operation runs; otherwise the status stays 0. The fault-to-log output follows this status.
- R6: A change of bit 26 updates the queued-invalidation status and its enable output, with neither a flush request nor a drain request.
- R7: A change of bit 25 raises the drain request. The remapping status and its enable output keep their old value until the cycle after drain-done is seen high.
- R8: Operations run one at a time, in the order flush, fault-log, queued-invalidation, remapping. The flush request and the drain request are never high together.
- R9: A write that asks for no operation (bit 27 = 0, and bits 28, 26 and 25 equal to the current status) produces one done pulse in the cycle after the write, with no handshake.
- R10: A write that arrives while a sequence is in progress is ignored.
- R11: Each completed operation produces a done pulse exactly one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Command word write strobe |
| wr_data_i | input | REG_W | Command word write data |
| rd_sel_i | input | 1 | Read select: 0 command word, 1 status word |
| rd_data_o | output | REG_W | Read data |
| ptr_valid_i | input | 1 | Fault-log pointer has been set |
| wbf_req_o | output | 1 | Write-buffer flush request |
| wbf_ack_i | input | 1 | Write-buffer flush acknowledge |
| drain_req_o | output | 1 | Request to drain queued interrupts |
| drain_done_i | input | 1 | Interrupt drain complete |
| fault_to_log_o | output | 1 | Faults routed to memory log (1) or recording registers (0) |
| qinv_en_o | output | 1 | Queued invalidation enabled |
| irmap_en_o | output | 1 | Interrupt remapping enabled |
| cmd_done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default 32-bit register width. At that width all four command positions and the unused bits of the word can be reached. Directed sequences hold the flush acknowledge and the drain completion low for several cycles. This shows that status only moves on the handshake edge. One write that requests every operation at once exposes the priority order, one done pulse per step. A write issued during a flush shows that the block ignores writes while it is busy.

// File: rtl/remap_pkg.sv
package remap_pkg;
    localparam int REG_W   = 32;
    localparam int FL_BIT  = 28;
    localparam int WBF_BIT = 27;
    localparam int QI_BIT  = 26;
    localparam int IR_BIT  = 25;

    // operation slots, lower index runs first
    localparam int N_OPS  = 4;
    localparam int OP_WBF = 0;
    localparam int OP_FL  = 1;
    localparam int OP_QI  = 2;
    localparam int OP_IR  = 3;

    typedef struct packed {
        logic fl;
        logic wbf;
        logic qi;
        logic ir;
    } gsts_t;

    typedef struct packed {
        logic fl;
        logic qi;
        logic ir;
    } gtgt_t;

    typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_FLUSH, SQ_DRAIN} sq_state_t;

    function automatic logic [REG_W-1:0] pack_sts(gsts_t s);
        logic [REG_W-1:0] w;
        w = '0;
        w[FL_BIT]  = s.fl;
        w[WBF_BIT] = s.wbf;
        w[QI_BIT]  = s.qi;
        w[IR_BIT]  = s.ir;
        return w;
    endfunction
endpackage

// File: rtl/remap_cmd_decode.sv
module remap_cmd_decode
    import remap_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic [W-1:0]     wdata,
    input  gsts_t            cur,
    output logic [N_OPS-1:0] pend,
    output gtgt_t            tgt
);
    always_comb begin
        tgt.fl = wdata[FL_BIT];
        tgt.qi = wdata[QI_BIT];
        tgt.ir = wdata[IR_BIT];
        pend         = '0;
        pend[OP_WBF] = wdata[WBF_BIT];
        pend[OP_FL]  = (tgt.fl != cur.fl);
        pend[OP_QI]  = (tgt.qi != cur.qi);
        pend[OP_IR]  = (tgt.ir != cur.ir);
    end
endmodule

// File: rtl/remap_prio_pick.sv
module remap_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]  = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end

    assign any = seen[N];
endmodule

// File: rtl/remap_gcmd_top.sv
module remap_gcmd_top
    import remap_pkg::*;
#(
    parameter int REG_W = remap_pkg::REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             rd_sel_i,
    output logic [REG_W-1:0] rd_data_o,
    input  logic             ptr_valid_i,
    output logic             wbf_req_o,
    input  logic             wbf_ack_i,
    output logic             drain_req_o,
    input  logic             drain_done_i,
    output logic             fault_to_log_o,
    output logic             qinv_en_o,
    output logic             irmap_en_o,
    output logic             cmd_done_o
);
    sq_state_t        state_q;
    gsts_t            sts_q;
    gtgt_t            tgt_q, tgt_w;
    logic [N_OPS-1:0] pend_q, pend_w, grant;
    logic             any_pend;
    logic             done_q, wbf_req_q, drain_req_q;

    remap_cmd_decode #(.W(REG_W)) u_dec (
        .wdata (wr_data_i),
        .cur   (sts_q),
        .pend  (pend_w),
        .tgt   (tgt_w)
    );

    remap_prio_pick #(.N(N_OPS)) u_pick (
        .req   (pend_q),
        .grant (grant),
        .any   (any_pend)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SQ_IDLE;
            sts_q       <= '0;
            tgt_q       <= '0;
            pend_q      <= '0;
            done_q      <= 1'b0;
            wbf_req_q   <= 1'b0;
            drain_req_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SQ_IDLE: if (wr_en_i) begin
                    pend_q <= pend_w;
                    tgt_q  <= tgt_w;
                    if (pend_w == '0) done_q  <= 1'b1;
                    else              state_q <= SQ_RUN;
                end
                SQ_RUN: begin
                    if (!any_pend) begin
                        state_q <= SQ_IDLE;
                    end else if (grant[OP_WBF]) begin
                        sts_q.wbf <= 1'b1;
                        wbf_req_q <= 1'b1;
                        state_q   <= SQ_FLUSH;
                    end else if (grant[OP_FL]) begin
                        if (!tgt_q.fl || ptr_valid_i) sts_q.fl <= tgt_q.fl;
                        pend_q[OP_FL] <= 1'b0;
                        done_q        <= 1'b1;
                    end else if (grant[OP_QI]) begin
                        sts_q.qi      <= tgt_q.qi;
                        pend_q[OP_QI] <= 1'b0;
                        done_q        <= 1'b1;
                    end else if (grant[OP_IR]) begin
                        drain_req_q <= 1'b1;
                        state_q     <= SQ_DRAIN;
                    end
                end
                SQ_FLUSH: if (wbf_ack_i) begin
                    wbf_req_q      <= 1'b0;
                    sts_q.wbf      <= 1'b0;
                    pend_q[OP_WBF] <= 1'b0;
                    done_q         <= 1'b1;
                    state_q        <= SQ_RUN;
                end
                SQ_DRAIN: if (drain_done_i) begin
                    drain_req_q   <= 1'b0;
                    sts_q.ir      <= tgt_q.ir;
                    pend_q[OP_IR] <= 1'b0;
                    done_q        <= 1'b1;
                    state_q       <= SQ_RUN;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign rd_data_o      = rd_sel_i ? pack_sts(sts_q) : '0;
    assign wbf_req_o      = wbf_req_q;
    assign drain_req_o    = drain_req_q;
    assign fault_to_log_o = sts_q.fl;
    assign qinv_en_o      = sts_q.qi;
    assign irmap_en_o     = sts_q.ir;
    assign cmd_done_o     = done_q;

    // R7
    ir_drain_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(irmap_en_o) |-> $past(drain_req_o && drain_done_i));

    // R5
    fl_ptr_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_to_log_o) |-> $past(ptr_valid_i));

    // R3
    wbf_ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wbf_req_o) |-> ($past(wbf_ack_i) && cmd_done_o));

    // R8
    one_op_chk: assert property (@(posedge clk) disable iff (rst)
        !(wbf_req_o && drain_req_o));

    // R6
    qi_no_hs_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(qinv_en_o) |-> (cmd_done_o && !wbf_req_o && !drain_req_o));
endmodule

// File: tb/remap_gcmd_top_tb.sv
`timescale 1ns/1ps
module remap_gcmd_top_tb;
    localparam int W = 32;
    localparam logic [W-1:0] B_FL  = 32'h1000_0000;
    localparam logic [W-1:0] B_WBF = 32'h0800_0000;
    localparam logic [W-1:0] B_QI  = 32'h0400_0000;
    localparam logic [W-1:0] B_IR  = 32'h0200_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, rd_sel = 1'b1, ptr_valid = 1'b0;
    logic wbf_ack = 1'b0, drain_done = 1'b0;
    logic [W-1:0] wr_data = '0, rd_data;
    logic wbf_req, drain_req, fault_to_log, qinv_en, irmap_en, cmd_done;
    int checks = 0, failures = 0;

    always #2.5 clk = ~clk;

    remap_gcmd_top #(.REG_W(W)) u_dut (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_sel_i(rd_sel), .rd_data_o(rd_data), .ptr_valid_i(ptr_valid),
        .wbf_req_o(wbf_req), .wbf_ack_i(wbf_ack), .drain_req_o(drain_req),
        .drain_done_i(drain_done), .fault_to_log_o(fault_to_log),
        .qinv_en_o(qinv_en), .irmap_en_o(irmap_en), .cmd_done_o(cmd_done)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_bit(input logic act, input logic exp, input string req);
        check(act === exp, req, {{(W-1){1'b0}}, act}, {{(W-1){1'b0}}, exp});
    endtask

    task automatic chk_sts(input logic fl, input logic wbf, input logic qi,
                           input logic ir, input string req);
        logic [W-1:0] e;
        e = (fl ? B_FL : '0) | (wbf ? B_WBF : '0) | (qi ? B_QI : '0) | (ir ? B_IR : '0);
        rd_sel = 1'b1;
        #0.1;
        check(rd_data === e, req, rd_data, e);
    endtask

    task automatic write_cmd(input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk_sts(0, 0, 0, 0, "R1 status after reset");
        chk_bit(wbf_req, 1'b0, "R1 flush req");
        chk_bit(drain_req, 1'b0, "R1 drain req");
        chk_bit(cmd_done, 1'b0, "R1 done");
        chk_bit(fault_to_log | qinv_en | irmap_en, 1'b0, "R1 enables");
    endtask

    task automatic t_cmd_read;
        rd_sel = 1'b0;
        #0.1;
        check(rd_data === '0, "R2 command read is zero", rd_data, '0);
        rd_sel = 1'b1;
    endtask

    task automatic t_flush;
        write_cmd(B_WBF);
        @(negedge clk);
        chk_bit(wbf_req, 1'b1, "R3 flush req raised");
        chk_sts(0, 1, 0, 0, "R3 flush status in progress");
        idle_cycles(3);
        chk_bit(wbf_req, 1'b1, "R3 flush held without ack");
        wbf_ack = 1'b1;
        @(negedge clk);
        wbf_ack = 1'b0;
        chk_bit(wbf_req, 1'b0, "R3 flush req cleared by ack");
        chk_bit(cmd_done, 1'b1, "R11 done on flush");
        chk_sts(0, 0, 0, 0, "R3 flush status cleared");
        @(negedge clk);
        chk_bit(cmd_done, 1'b0, "R11 done is one cycle");
        idle_cycles(2);
    endtask

    task automatic t_flush_zero;
        write_cmd('0);
        chk_bit(cmd_done, 1'b1, "R9 noop write done pulse");
        @(negedge clk);
        chk_bit(cmd_done, 1'b0, "R11 noop done one cycle");
        chk_bit(wbf_req, 1'b0, "R4 zero write no flush");
        chk_sts(0, 0, 0, 0, "R4 status unchanged");
        idle_cycles(2);
    endtask

    task automatic t_fl_noptr;
        ptr_valid = 1'b0;
        write_cmd(B_FL);
        @(negedge clk);
        chk_bit(cmd_done, 1'b1, "R5 fault-log op completes");
        chk_sts(0, 0, 0, 0, "R5 enable refused without pointer");
        chk_bit(fault_to_log, 1'b0, "R5 faults stay on registers");
        idle_cycles(2);
    endtask

    task automatic t_fl_ptr;
        ptr_valid = 1'b1;
        write_cmd(B_FL);
        @(negedge clk);
        chk_bit(cmd_done, 1'b1, "R5 fault-log op done");
        chk_sts(1, 0, 0, 0, "R5 enable honoured with pointer");
        chk_bit(fault_to_log, 1'b1, "R5 faults routed to log");
        t_cmd_read();
        idle_cycles(2);
    endtask

    task automatic t_qi;
        write_cmd(B_FL | B_QI);
        @(negedge clk);
        chk_bit(cmd_done, 1'b1, "R6 qi done");
        chk_bit(qinv_en, 1'b1, "R6 qi enabled");
        chk_bit(wbf_req | drain_req, 1'b0, "R6 no handshake");
        chk_sts(1, 0, 1, 0, "R6 status");
        idle_cycles(2);
    endtask

    task automatic t_ir;
        write_cmd(B_FL | B_QI | B_IR);
        @(negedge clk);
        chk_bit(drain_req, 1'b1, "R7 drain requested");
        idle_cycles(4);
        chk_bit(irmap_en, 1'b0, "R7 enable waits for drain");
        chk_sts(1, 0, 1, 0, "R7 status waits for drain");
        drain_done = 1'b1;
        @(negedge clk);
        drain_done = 1'b0;
        chk_bit(irmap_en, 1'b1, "R7 enabled after drain");
        chk_bit(cmd_done, 1'b1, "R11 done after drain");
        chk_bit(drain_req, 1'b0, "R7 drain req dropped");
        idle_cycles(2);
    endtask

    task automatic t_busy;
        write_cmd(B_FL | B_WBF | B_QI | B_IR);
        @(negedge clk);
        chk_bit(wbf_req, 1'b1, "R10 flush running");
        write_cmd(B_FL | B_IR);
        wbf_ack = 1'b1;
        @(negedge clk);
        wbf_ack = 1'b0;
        idle_cycles(3);
        chk_bit(qinv_en, 1'b1, "R10 busy write ignored");
        chk_sts(1, 0, 1, 1, "R10 status after busy write");
    endtask

    task automatic t_order;
        write_cmd(B_WBF);
        @(negedge clk);
        chk_bit(wbf_req, 1'b1, "R8 flush first");
        chk_bit(drain_req, 1'b0, "R8 no drain during flush");
        chk_bit(fault_to_log, 1'b1, "R8 fault-log waits for flush");
        wbf_ack = 1'b1;
        @(negedge clk);
        wbf_ack = 1'b0;
        chk_bit(cmd_done, 1'b1, "R8 flush done");
        chk_bit(fault_to_log, 1'b1, "R8 fault-log not yet");
        @(negedge clk);
        chk_bit(fault_to_log, 1'b0, "R8 fault-log second");
        chk_bit(qinv_en, 1'b1, "R8 qi not yet");
        chk_bit(cmd_done, 1'b1, "R11 done for fault-log");
        @(negedge clk);
        chk_bit(qinv_en, 1'b0, "R8 qi third");
        chk_bit(drain_req, 1'b0, "R8 drain not yet");
        @(negedge clk);
        chk_bit(drain_req, 1'b1, "R8 remap last");
        chk_bit(cmd_done, 1'b0, "R11 no done while draining");
        chk_bit(irmap_en, 1'b1, "R7 disable waits for drain");
        drain_done = 1'b1;
        @(negedge clk);
        drain_done = 1'b0;
        chk_bit(irmap_en, 1'b0, "R7 disabled after drain");
        idle_cycles(2);
        chk_sts(0, 0, 0, 0, "R8 final status");
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle_cycles(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cmd_read();
        t_flush();
        t_flush_zero();
        t_fl_noptr();
        t_fl_ptr();
        t_qi();
        t_ir();
        t_busy();
        t_order();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule